// File: doc/BRIEF.md
# Word-Window AXI4-Lite Master Bridge

This block gives a host with a narrow 16-bit register port a way to run single 32-bit reads and writes on an AXI4-Lite master port. The host assembles the target address and the outgoing data from 16-bit halves held in separate registers. It then writes a command code into the control register. The bridge carries out one AXI transaction with all four byte strobes set.

The host learns the result in one of two ways. It can poll the status register until busy drops, or it can wait on the interrupt line. Each transfer ends with exactly one latched outcome: completion, error or timeout. A read also returns its data in two 16-bit halves.

Outcome flags stay set until the host clears them by writing ones to them. Each flag can be routed to the interrupt line through an enable bit in the control register. Two command variants step the stored address by one word after a successful transfer, so the host can walk through consecutive locations.

Top module: `hw16_axil_bridge`

## Requirements
- R1: Eight 16-bit registers are selected by a 3-bit host index. 0 is status, 1 is control, 2/3 are address low/high, 4/5 are write data low/high and 6/7 are read data low/high. Address and write-data halves read back what was written. Status and control read 0 right after reset.
- R2: Control code 0x8 (in bits 3:0) starts an AXI write. The address is {reg3,reg2}, the data is {reg5,reg4] and the strobe is 4'hF. With an OKAY response, status bit 14 is set. Busy (status bit 6) stays high for 2 + slave-latency cycles.
- R3: Code 0xA starts an AXI read from {reg3,reg2}. With an OKAY response, the data appears in reg7:reg6, status bit 15 (read complete) and bit 7 (read data available) are set, and busy lasts 2 + slave-latency cycles.
- R4: A host read of register 7 clears status bit 7. A read of register 6 leaves it set.
- R5: A nonzero BRESP or RRESP sets status bit 12 (error) and not the complete bit. It also leaves the stored address unchanged, even for a post-increment code.
- R6: If no response arrives, the transfer is abandoned exactly TIMEOUT_CYCLES cycles after it was accepted. Status bit 13 is set, and the channel valid/ready outputs drop to 0.
- R7: Codes 0x9 and 0xB act like 0x8 and 0xA. After a successful transfer they also add 4 to the 32-bit address, with the carry going from reg2 into reg3. Plain codes leave the address as it was.
- R8: Event bits 15..11 of status stay set until cleared. Writing status clears each event bit written as 1 and leaves the bits written as 0.
- R9: A command written while busy is ignored. Code 0x0 and undefined codes start nothing. Enable bits are still updated on any control write.
- R10: irq_o is high exactly when some status event bit 15..11 is set and its enable, at the same position of the control register, is also set.
- R11: The ext_int_i input sets status bit 11.
- R12: Status bit 5 (init done) is low after reset. It rises INIT_CYCLES cycles after reset is released and stays high.
- R13: Every accepted transfer ends with exactly one of the outcomes complete, error or timeout, and the bridge is idle the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr_i | input | 3 | Host register index |
| host_we_i | input | 1 | Host write strobe |
| host_re_i | input | 1 | Host read strobe (side effect on register 7) |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data, combinational from index |
| ext_int_i | input | 1 | External event input for status bit 11 |
| irq_o | output | 1 | Interrupt, enabled events ORed |
| m_awaddr_o | output | 32 | AXI write address |
| m_awvalid_o | output | 1 | AXI write address valid |
| m_awready_i | input | 1 | AXI write address ready |
| m_wdata_o | output | 32 | AXI write data |
| m_wstrb_o | output | 4 | AXI write strobes |
| m_wvalid_o | output | 1 | AXI write data valid |
| m_wready_i | input | 1 | AXI write data ready |
| m_bresp_i | input | 2 | AXI write response |
| m_bvalid_i | input | 1 | AXI write response valid |
| m_bready_o | output | 1 | AXI write response ready |
| m_araddr_o | output | 32 | AXI read address |
| m_arvalid_o | output | 1 | AXI read address valid |
| m_arready_i | input | 1 | AXI read address ready |
| m_rdata_i | input | 32 | AXI read data |
| m_rresp_i | input | 2 | AXI read response |
| m_rvalid_i | input | 1 | AXI read data valid |
| m_rready_o | output | 1 | AXI read data ready |

## Verification
A transfer accepted at edge E0 is in its address phase after E0. Its request handshakes at E1 with an always-ready slave. With a slave latency of L cycles, the response completes at E2+L, so busy is high for exactly 2+L sampled cycles; a timed-out transfer is busy for TIMEOUT_CYCLES cycles. The driver arms the monitor just after E0. The monitor counts every falling edge from then until it first sees busy low, and compares that count and the latched event bits with the item the driver queued. Register side effects (clears, readback, post-increment) are single-edge and are sampled at the falling edge after the writing edge.

// File: rtl/hw16_axil_pkg.sv
package hw16_axil_pkg;

    localparam int HOST_W  = 16;
    localparam int IDX_W   = 3;
    localparam int AXI_AW  = 32;
    localparam int AXI_DW  = 32;
    localparam int STRB_W  = AXI_DW / 8;
    localparam int CMD_W   = 4;
    localparam int N_EV    = 5;
    localparam int EV_LSB  = 11;

    typedef enum logic [IDX_W-1:0] {
        REG_STAT = 3'd0,
        REG_CTRL = 3'd1,
        REG_ADRL = 3'd2,
        REG_ADRH = 3'd3,
        REG_WDL  = 3'd4,
        REG_WDH  = 3'd5,
        REG_RDL  = 3'd6,
        REG_RDH  = 3'd7
    } reg_idx_e;

    // event vector index, mapped onto status bits EV_LSB + index
    localparam int EVI_INT = 0;
    localparam int EVI_ERR = 1;
    localparam int EVI_TMO = 2;
    localparam int EVI_WR  = 3;
    localparam int EVI_RD  = 4;

    localparam int B_RDAV  = 7;
    localparam int B_BUSY  = 6;
    localparam int B_INIT  = 5;

    typedef struct packed {
        logic valid;
        logic is_read;
        logic post_inc;
    } cmd_dec_t;

    typedef struct packed {
        logic ok;
        logic err;
        logic tmo;
        logic is_read;
    } outcome_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREQ,
        ST_WRESP,
        ST_RREQ,
        ST_RRESP
    } eng_state_e;

    function automatic cmd_dec_t decode_cmd(input logic [CMD_W-1:0] code);
        cmd_dec_t d;
        d = '0;
        case (code)
            4'h8: begin d.valid = 1'b1; end
            4'h9: begin d.valid = 1'b1; d.post_inc = 1'b1; end
            4'hA: begin d.valid = 1'b1; d.is_read = 1'b1; end
            4'hB: begin d.valid = 1'b1; d.is_read = 1'b1; d.post_inc = 1'b1; end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hw16_axil_events.sv
module hw16_axil_events
    import hw16_axil_pkg::*;
#(
    parameter int N = N_EV
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] ev_o,
    output logic         irq_o
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;

        always_ff @(posedge clk) begin
            if (rst)
                flag_q <= 1'b0;
            else if (set_i[i])
                flag_q <= 1'b1;
            else if (clr_i[i])
                flag_q <= 1'b0;
        end

        assign ev_o[i] = flag_q;

        AST_STICKY: assert property (@(posedge clk) disable iff (rst)
            (flag_q && !clr_i[i]) |=> flag_q); // R8
    end

    assign irq_o = |(ev_o & en_i);

endmodule

// File: rtl/hw16_axil_engine.sv
module hw16_axil_engine
    import hw16_axil_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              start_rd_i,
    input  logic [AXI_AW-1:0] addr_i,
    input  logic [AXI_DW-1:0] wdata_i,
    output logic              busy_o,
    output outcome_t          done_o,
    output logic [AXI_AW-1:0] m_awaddr_o,
    output logic              m_awvalid_o,
    input  logic              m_awready_i,
    output logic [AXI_DW-1:0] m_wdata_o,
    output logic [STRB_W-1:0] m_wstrb_o,
    output logic              m_wvalid_o,
    input  logic              m_wready_i,
    input  logic [1:0]        m_bresp_i,
    input  logic              m_bvalid_i,
    output logic              m_bready_o,
    output logic [AXI_AW-1:0] m_araddr_o,
    output logic              m_arvalid_o,
    input  logic              m_arready_i,
    input  logic [1:0]        m_rresp_i,
    input  logic              m_rvalid_i,
    output logic              m_rready_o
);

    localparam int          CW       = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYCLES - 1);

    eng_state_e        state_q;
    logic [AXI_AW-1:0] addr_q;
    logic [AXI_DW-1:0] wdata_q;
    logic [CW-1:0]     cnt_q;
    logic              aw_done_q, w_done_q;

    logic aw_hs, w_hs, ar_hs, resp_hs, tmo_now, is_rd_phase;
    logic [1:0] resp_code;

    assign busy_o      = (state_q != ST_IDLE);
    assign m_awvalid_o = (state_q == ST_WREQ) && !aw_done_q;
    assign m_wvalid_o  = (state_q == ST_WREQ) && !w_done_q;
    assign m_bready_o  = (state_q == ST_WRESP);
    assign m_arvalid_o = (state_q == ST_RREQ);
    assign m_rready_o  = (state_q == ST_RRESP);
    assign m_awaddr_o  = addr_q;
    assign m_araddr_o  = addr_q;
    assign m_wdata_o   = wdata_q;
    assign m_wstrb_o   = '1;

    assign aw_hs       = m_awvalid_o && m_awready_i;
    assign w_hs        = m_wvalid_o && m_wready_i;
    assign ar_hs       = m_arvalid_o && m_arready_i;
    assign resp_hs     = (m_bready_o && m_bvalid_i) || (m_rready_o && m_rvalid_i);
    assign resp_code   = (state_q == ST_RRESP) ? m_rresp_i : m_bresp_i;
    assign tmo_now     = busy_o && (cnt_q == CNT_LAST) && !resp_hs;
    assign is_rd_phase = (state_q == ST_RREQ) || (state_q == ST_RRESP);

    always_comb begin
        done_o         = '0;
        done_o.ok      = resp_hs && (resp_code == 2'b00);
        done_o.err     = resp_hs && (resp_code != 2'b00);
        done_o.tmo     = tmo_now;
        done_o.is_read = is_rd_phase;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            wdata_q   <= '0;
            cnt_q     <= '0;
            aw_done_q <= 1'b0;
            w_done_q  <= 1'b0;
        end else begin
            if (busy_o)
                cnt_q <= cnt_q + 1'b1;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        addr_q    <= addr_i;
                        wdata_q   <= wdata_i;
                        cnt_q     <= '0;
                        aw_done_q <= 1'b0;
                        w_done_q  <= 1'b0;
                        state_q   <= start_rd_i ? ST_RREQ : ST_WREQ;
                    end
                end
                ST_WREQ: begin
                    if (aw_hs) aw_done_q <= 1'b1;
                    if (w_hs)  w_done_q  <= 1'b1;
                    if ((aw_done_q || aw_hs) && (w_done_q || w_hs))
                        state_q <= ST_WRESP;
                end
                ST_RREQ: begin
                    if (ar_hs)
                        state_q <= ST_RRESP;
                end
                ST_WRESP, ST_RRESP: begin
                    if (resp_hs)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
            if (tmo_now)
                state_q <= ST_IDLE;
        end
    end

    AST_AW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (m_awvalid_o && !m_awready_i && !tmo_now) |=> (m_awvalid_o && $stable(m_awaddr_o))); // R2

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(m_awaddr_o)); // R9

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (done_o.ok || done_o.err || done_o.tmo) |=> !busy_o); // R13

    AST_TMO_WINDOW: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (cnt_q < CW'(TIMEOUT_CYCLES))); // R6

endmodule

// File: rtl/hw16_axil_bridge.sv
module hw16_axil_bridge
    import hw16_axil_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1024,
    parameter int INIT_CYCLES    = 16,
    parameter int ADDR_STEP      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        host_addr_i,
    input  logic              host_we_i,
    input  logic              host_re_i,
    input  logic [15:0]       host_wdata_i,
    output logic [15:0]       host_rdata_o,
    input  logic              ext_int_i,
    output logic              irq_o,
    output logic [31:0]       m_awaddr_o,
    output logic              m_awvalid_o,
    input  logic              m_awready_i,
    output logic [31:0]       m_wdata_o,
    output logic [3:0]        m_wstrb_o,
    output logic              m_wvalid_o,
    input  logic              m_wready_i,
    input  logic [1:0]        m_bresp_i,
    input  logic              m_bvalid_i,
    output logic              m_bready_o,
    output logic [31:0]       m_araddr_o,
    output logic              m_arvalid_o,
    input  logic              m_arready_i,
    input  logic [31:0]       m_rdata_i,
    input  logic [1:0]        m_rresp_i,
    input  logic              m_rvalid_i,
    output logic              m_rready_o
);

    localparam int IW = $clog2(INIT_CYCLES + 1);
    localparam logic [IW-1:0] INIT_END = IW'(INIT_CYCLES);

    logic [N_EV-1:0]   en_q, ev, ev_set, ev_clr;
    logic [AXI_AW-1:0] adr_q;
    logic [AXI_DW-1:0] wd_q, rd_q;
    logic              rdav_q, pinc_q, busy, init_done, start, irq;
    logic [IW-1:0]     init_cnt_q;
    cmd_dec_t          dec;
    outcome_t          done;

    logic wr_stat, wr_ctrl, wr_adrl, wr_adrh;
    assign wr_stat = host_we_i && (host_addr_i == REG_STAT);
    assign wr_ctrl = host_we_i && (host_addr_i == REG_CTRL);
    assign wr_adrl = host_we_i && (host_addr_i == REG_ADRL);
    assign wr_adrh = host_we_i && (host_addr_i == REG_ADRH);

    assign dec   = decode_cmd(host_wdata_i[CMD_W-1:0]);
    assign start = wr_ctrl && dec.valid && !busy;

    // init-done timer
    always_ff @(posedge clk) begin
        if (rst)
            init_cnt_q <= '0;
        else if (init_cnt_q != INIT_END)
            init_cnt_q <= init_cnt_q + 1'b1;
    end
    assign init_done = (init_cnt_q == INIT_END);

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            adr_q  <= '0;
            wd_q   <= '0;
            rd_q   <= '0;
            rdav_q <= 1'b0;
            pinc_q <= 1'b0;
        end else begin
            if (wr_ctrl)
                en_q <= host_wdata_i[EV_LSB +: N_EV];
            if (start)
                pinc_q <= dec.post_inc;

            if (wr_adrl)
                adr_q[15:0] <= host_wdata_i;
            if (wr_adrh)
                adr_q[31:16] <= host_wdata_i;
            if (!wr_adrl && !wr_adrh && done.ok && pinc_q)
                adr_q <= adr_q + AXI_AW'(ADDR_STEP);

            if (host_we_i && host_addr_i == REG_WDL)
                wd_q[15:0] <= host_wdata_i;
            if (host_we_i && host_addr_i == REG_WDH)
                wd_q[31:16] <= host_wdata_i;

            if (done.ok && done.is_read) begin
                rd_q   <= m_rdata_i;
                rdav_q <= 1'b1;
            end else if (host_re_i && host_addr_i == REG_RDH) begin
                rdav_q <= 1'b0;
            end
        end
    end

    always_comb begin
        ev_set          = '0;
        ev_set[EVI_RD]  = done.ok && done.is_read;
        ev_set[EVI_WR]  = done.ok && !done.is_read;
        ev_set[EVI_TMO] = done.tmo;
        ev_set[EVI_ERR] = done.err;
        ev_set[EVI_INT] = ext_int_i;
        ev_clr          = wr_stat ? host_wdata_i[EV_LSB +: N_EV] : '0;
    end

    hw16_axil_events #(.N(N_EV)) u_events (
        .clk   (clk),
        .rst   (rst),
        .set_i (ev_set),
        .clr_i (ev_clr),
        .en_i  (en_q),
        .ev_o  (ev),
        .irq_o (irq)
    );
    assign irq_o = irq;

    hw16_axil_engine #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .start_rd_i  (dec.is_read),
        .addr_i      (adr_q),
        .wdata_i     (wd_q),
        .busy_o      (busy),
        .done_o      (done),
        .m_awaddr_o  (m_awaddr_o),
        .m_awvalid_o (m_awvalid_o),
        .m_awready_i (m_awready_i),
        .m_wdata_o   (m_wdata_o),
        .m_wstrb_o   (m_wstrb_o),
        .m_wvalid_o  (m_wvalid_o),
        .m_wready_i  (m_wready_i),
        .m_bresp_i   (m_bresp_i),
        .m_bvalid_i  (m_bvalid_i),
        .m_bready_o  (m_bready_o),
        .m_araddr_o  (m_araddr_o),
        .m_arvalid_o (m_arvalid_o),
        .m_arready_i (m_arready_i),
        .m_rresp_i   (m_rresp_i),
        .m_rvalid_i  (m_rvalid_i),
        .m_rready_o  (m_rready_o)
    );

    // host read mux
    always_comb begin
        host_rdata_o = '0;
        case (host_addr_i)
            REG_STAT: begin
                host_rdata_o[EV_LSB +: N_EV] = ev;
                host_rdata_o[B_RDAV]         = rdav_q;
                host_rdata_o[B_BUSY]         = busy;
                host_rdata_o[B_INIT]         = init_done;
            end
            REG_CTRL: host_rdata_o[EV_LSB +: N_EV] = en_q;
            REG_ADRL: host_rdata_o = adr_q[15:0];
            REG_ADRH: host_rdata_o = adr_q[31:16];
            REG_WDL:  host_rdata_o = wd_q[15:0];
            REG_WDH:  host_rdata_o = wd_q[31:16];
            REG_RDL:  host_rdata_o = rd_q[15:0];
            REG_RDH:  host_rdata_o = rd_q[31:16];
            default:  host_rdata_o = '0;
        endcase
    end

    AST_INIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R12

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_adrl && !wr_adrh && !(done.ok && pinc_q)) |=> $stable(adr_q)); // R7

    AST_RDAV_SET: assert property (@(posedge clk) disable iff (rst)
        (done.ok && done.is_read) |=> rdav_q); // R3

endmodule

// File: tb/hw16_axil_bridge_tb_top.sv
`timescale 1ns/1ps
module hw16_axil_bridge_tb_top;

    localparam int TMO  = 12;
    localparam int INIT = 8;
    localparam logic [31:0] RMASK = 32'h5A5A_C3C3;

    logic        clk = 1'b0, rst = 1'b1;
    logic [2:0]  host_addr = 3'd0;
    logic        host_we = 1'b0, host_re = 1'b0;
    logic [15:0] host_wdata = '0, host_rdata;
    logic        ext_int = 1'b0, irq;
    logic [31:0] awaddr, wdata, araddr, rdata;
    logic [3:0]  wstrb;
    logic        awvalid, wvalid, bready, arvalid, rready;
    logic        bvalid = 1'b0, rvalid = 1'b0;
    logic [1:0]  bresp = 2'b00, rresp = 2'b00;

    always #2 clk = ~clk;

    hw16_axil_bridge #(.TIMEOUT_CYCLES(TMO), .INIT_CYCLES(INIT), .ADDR_STEP(4)) dut_i (
        .clk(clk), .rst(rst),
        .host_addr_i(host_addr), .host_we_i(host_we), .host_re_i(host_re),
        .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
        .ext_int_i(ext_int), .irq_o(irq),
        .m_awaddr_o(awaddr), .m_awvalid_o(awvalid), .m_awready_i(1'b1),
        .m_wdata_o(wdata), .m_wstrb_o(wstrb), .m_wvalid_o(wvalid), .m_wready_i(1'b1),
        .m_bresp_i(bresp), .m_bvalid_i(bvalid), .m_bready_o(bready),
        .m_araddr_o(araddr), .m_arvalid_o(arvalid), .m_arready_i(1'b1),
        .m_rdata_i(rdata), .m_rresp_i(rresp), .m_rvalid_i(rvalid), .m_rready_o(rready)
    );

    int total = 0, bad = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // slave model
    int          s_lat = 0;
    logic        s_mute = 1'b0;
    logic [1:0]  s_resp = 2'b00;
    int          bcnt = 0, rcnt = 0, aw_n = 0, ar_n = 0;
    logic [31:0] cap_awaddr = '0, cap_wdata = '0, cap_araddr = '0;
    logic [3:0]  cap_wstrb = '0;

    always @(posedge clk) begin
        if (bvalid && bready) bvalid <= 1'b0;
        if (rvalid && rready) rvalid <= 1'b0;
        if (wvalid) begin cap_wdata <= wdata; cap_wstrb <= wstrb; end
        if (awvalid) begin
            cap_awaddr <= awaddr;
            aw_n <= aw_n + 1;
            if (!s_mute) begin
                bresp <= s_resp;
                if (s_lat == 0) bvalid <= 1'b1; else bcnt <= s_lat;
            end
        end else if (bcnt != 0) begin
            bcnt <= bcnt - 1;
            if (bcnt == 1) bvalid <= 1'b1;
        end
        if (arvalid) begin
            cap_araddr <= araddr;
            ar_n <= ar_n + 1;
            rdata <= araddr ^ RMASK;
            if (!s_mute) begin
                rresp <= s_resp;
                if (s_lat == 0) rvalid <= 1'b1; else rcnt <= s_lat;
            end
        end else if (rcnt != 0) begin
            rcnt <= rcnt - 1;
            if (rcnt == 1) rvalid <= 1'b1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // scoreboard
    typedef struct { int lat; logic [15:0] ev; string req; } exp_t;
    exp_t sb_q[$];
    exp_t mon_e;
    logic armed = 1'b0;
    int   mon_cnt = 0;

    always @(negedge clk) begin
        if (armed) begin
            if (host_addr == 3'd0 && !host_we && !host_rdata[6]) begin
                mon_e = sb_q.pop_front();
                chk({mon_e.req, " latency"}, mon_cnt, mon_e.lat);
                chk({mon_e.req, " events"}, {16'h0, host_rdata & 16'hF800}, {16'h0, mon_e.ev});
                armed = 1'b0;
            end else begin
                mon_cnt++;
            end
        end
    end

    logic [4:0] en_bits = '0;

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_we = 1'b0; host_addr = 3'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(posedge clk); #1;
        host_addr = a; host_re = 1'b1;
        @(negedge clk);
        d = host_rdata;
        @(posedge clk); #1;
        host_re = 1'b0; host_addr = 3'd0;
    endtask

    task automatic start_cmd(input logic [3:0] code, input int lat, input logic [15:0] ev, input string req);
        sb_q.push_back('{lat, ev, req});
        @(posedge clk); #1;
        host_we = 1'b1; host_addr = 3'd1; host_wdata = {en_bits, 7'b0, code};
        @(posedge clk); #1;
        host_we = 1'b0; host_addr = 3'd0; mon_cnt = 0; armed = 1'b1;
    endtask

    task automatic wait_done();
        while (armed) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 20000) begin
                bad++; total++;
                $display("FAIL watchdog act=%0d exp=done", cyc);
                summary();
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] d, lo, hi;
        int a0, r0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 / R12 reset state
        rd(3'd0, d); chk("R1 status reset", d, 16'h0000);
        chk("R12 init low", d[5], 1'b0);
        rd(3'd1, d); chk("R1 ctrl reset", d, 16'h0000);
        repeat (INIT) @(posedge clk);
        rd(3'd0, d); chk("R12 init high", d[5], 1'b1);

        // R1 readback
        wr(3'd2, 16'h1234); wr(3'd3, 16'hA000);
        wr(3'd4, 16'hBEEF); wr(3'd5, 16'hCAFE);
        rd(3'd2, d); chk("R1 adrl", d, 16'h1234);
        rd(3'd3, d); chk("R1 adrh", d, 16'hA000);
        rd(3'd4, d); chk("R1 wdl", d, 16'hBEEF);
        rd(3'd5, d); chk("R1 wdh", d, 16'hCAFE);

        // R2 write, zero and three cycle latency
        wr(3'd0, 16'hF800);
        start_cmd(4'h8, 2, 16'h4000, "R2 write lat0"); wait_done();
        chk("R2 awaddr", cap_awaddr, 32'hA000_1234);
        chk("R2 wdata", cap_wdata, 32'hCAFE_BEEF);
        chk("R2 wstrb", {28'h0, cap_wstrb}, 32'hF);
        rd(3'd2, d); chk("R7 plain no inc", d, 16'h1234);
        s_lat = 3;
        wr(3'd0, 16'hF800);
        start_cmd(4'h8, 5, 16'h4000, "R2 write lat3"); wait_done();

        // R3 read, R4 data-available clear
        s_lat = 1;
        wr(3'd0, 16'hF800);
        start_cmd(4'hA, 3, 16'h8000, "R3 read lat1"); wait_done();
        chk("R3 araddr", cap_araddr, 32'hA000_1234);
        rd(3'd0, d); chk("R3 rdav set", d[7], 1'b1);
        rd(3'd6, lo);
        rd(3'd0, d); chk("R4 rdav after low", d[7], 1'b1);
        rd(3'd7, hi);
        chk("R3 rdata", {hi, lo}, 32'hA000_1234 ^ RMASK);
        rd(3'd0, d); chk("R4 rdav cleared", d[7], 1'b0);

        // R5 error with post-inc code
        s_lat = 0; s_resp = 2'b10;
        wr(3'd0, 16'hF800);
        start_cmd(4'h9, 2, 16'h1000, "R5 write slverr"); wait_done();
        rd(3'd2, d); chk("R5 no inc", d, 16'h1234);
        s_resp = 2'b11;
        wr(3'd0, 16'hF800);
        start_cmd(4'hA, 2, 16'h1000, "R5 read decerr"); wait_done();
        s_resp = 2'b00;

        // R6 timeout
        s_mute = 1'b1;
        wr(3'd0, 16'hF800);
        start_cmd(4'hA, TMO, 16'h2000, "R6 read timeout"); wait_done();
        chk("R6 arvalid low", arvalid, 1'b0);
        chk("R6 rready low", rready, 1'b0);

        // R9 command while busy ignored
        a0 = aw_n;
        wr(3'd0, 16'hF800);
        start_cmd(4'hA, TMO, 16'h2000, "R9 busy read");
        repeat (2) @(posedge clk);
        #1; host_we = 1'b1; host_addr = 3'd1; host_wdata = {en_bits, 7'b0, 4'h8};
        @(posedge clk); #1; host_we = 1'b0; host_addr = 3'd0;
        wait_done();
        repeat (3) @(posedge clk);
        chk("R9 no write issued", aw_n, a0);
        s_mute = 1'b0;

        // R9 NOP and undefined code
        a0 = aw_n; r0 = ar_n;
        wr(3'd1, 16'h0000);
        rd(3'd0, d); chk("R9 nop not busy", d[6], 1'b0);
        wr(3'd1, 16'h0003);
        rd(3'd0, d); chk("R9 undef not busy", d[6], 1'b0);
        chk("R9 no traffic", aw_n + ar_n, a0 + r0);

        // R8 write-one-to-clear
        wr(3'd0, 16'hF800);
        start_cmd(4'h8, 2, 16'h4000, "R8 write"); wait_done();
        start_cmd(4'hA, 2, 16'hC000, "R8 read keeps write"); wait_done();
        wr(3'd0, 16'h4000);
        rd(3'd0, d); chk("R8 partial clear", {16'h0, d & 16'hF800}, 32'h8000);

        // R10 interrupt gating
        chk("R10 irq off no enable", irq, 1'b0);
        wr(3'd1, 16'h8000);
        chk("R10 irq on", irq, 1'b1);
        rd(3'd1, d); chk("R9 enables stored on nop", d, 16'h8000);
        wr(3'd1, 16'h4000);
        chk("R10 irq off other enable", irq, 1'b0);
        wr(3'd1, 16'h0000);

        // R11 external event
        wr(3'd0, 16'hF800);
        @(posedge clk); #1 ext_int = 1'b1;
        @(posedge clk); #1 ext_int = 1'b0;
        rd(3'd0, d); chk("R11 ext event", {16'h0, d & 16'hF800}, 32'h0800);
        wr(3'd1, 16'h0800);
        chk("R11 R10 irq ext", irq, 1'b1);
        wr(3'd0, 16'h0800);
        chk("R10 irq cleared", irq, 1'b0);
        wr(3'd1, 16'h0000);

        // R7 post-increment with carry
        wr(3'd2, 16'hFFFC); wr(3'd3, 16'h0000);
        wr(3'd0, 16'hF800);
        start_cmd(4'h9, 2, 16'h4000, "R7 write inc"); wait_done();
        chk("R7 awaddr", cap_awaddr, 32'h0000_FFFC);
        rd(3'd2, lo); rd(3'd3, hi);
        chk("R7 carry", {hi, lo}, 32'h0001_0000);
        wr(3'd0, 16'hF800);
        start_cmd(4'hB, 2, 16'h8000, "R7 read inc"); wait_done();
        chk("R7 araddr", cap_araddr, 32'h0001_0000);
        rd(3'd2, lo); rd(3'd3, hi);
        chk("R7 second inc", {hi, lo}, 32'h0001_0004);
        rd(3'd6, lo); rd(3'd7, hi);
        chk("R3 rdata inc", {hi, lo}, 32'h0001_0000 ^ RMASK);

        // R13 idle after each outcome
        rd(3'd0, d); chk("R13 idle", d[6], 1'b0);

        summary();
        $finish;
    end

endmodule